// File: doc/BRIEF.md
# UART Auto Powerdown Controller

This block decides, for each channel of a multi-channel UART, when the transmit half and the receive half may have their clocks or power removed. Each half goes to sleep on its own idle condition and wakes on its own event. It does not touch the serial datapath, the baud generator or the register decode. Configuration bits and status flags come in from those blocks, and one enable per half goes back out to the clock gates.

Software can force a channel down with a direct powerdown bit. A chip-level power-good input forces every channel down. The automatic behaviour runs only when a channel's auto enable bit is set. The RX line and the ring-indicator input pass through a synchronizer that is never gated. A change on the ring-indicator input therefore still produces an interrupt request while the channel sleeps.

Top module: `uart_pwr_ctl`

## Requirements
- R1: After reset, every tx_en_o and rx_en_o bit is 1 and every ri_irq_o bit is 0.
- R2: While dir_pd_i[c] is 1, tx_en_o[c] and rx_en_o[c] are 0. Other channels are unaffected.
- R3: While pwr_good_i is 0, all tx_en_o and rx_en_o bits are 0.
- R4: While auto_en_i[c] is 0, the halves of channel c never sleep, even when all idle flags are set.
- R5: With auto enabled, the transmitter of channel c sleeps when thr_empty_i[c] and tsr_empty_i[c] are both 1 at two consecutive rising edges. tx_en_o[c] goes to 0 after the second of those edges. A single empty flag is not enough.
- R6: With auto enabled, the receiver of channel c sleeps when rx_fifo_empty_i[c] and rx_idle_i[c] are both 1 at two consecutive rising edges. rx_en_o[c] goes to 0 after the second of those edges.
- R7: A 1 on thr_wr_i[c] raises tx_en_o[c] combinationally in the same cycle, unless the channel is forced down. The transmitter is awake after that edge.
- R8: A level change on rxd_i[c] wakes a sleeping receiver. rx_en_o[c] returns to 1 after the third rising edge following the change.
- R9: A level change on ri_i[c] gives a one-cycle pulse on ri_irq_o[c], visible after the second rising edge, whether or not the channel is powered down.
- R10: A transmit write in the cycle where sleep entry would happen wins, and the transmitter stays awake.
- R11: The transmit and receive halves, and different channels, sleep independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | UART clock, never gated |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_good_i | input | 1 | Chip power good; 0 forces all channels down |
| dir_pd_i | input | N_CH | Direct powerdown bit per channel |
| auto_en_i | input | N_CH | Auto powerdown enable per channel |
| thr_empty_i | input | N_CH | Transmit holding buffer empty |
| tsr_empty_i | input | N_CH | Transmit shift register empty |
| rx_fifo_empty_i | input | N_CH | Receive FIFO empty |
| rx_idle_i | input | N_CH | Receiver waiting for a start bit |
| thr_wr_i | input | N_CH | Host write strobe to the transmit buffer |
| rxd_i | input | N_CH | Serial receive line (asynchronous) |
| ri_i | input | N_CH | Ring-indicator input (asynchronous) |
| tx_en_o | output | N_CH | Transmitter clock/power enable |
| rx_en_o | output | N_CH | Receiver clock/power enable |
| ri_irq_o | output | N_CH | Ring-indicator change interrupt request |

## Verification
The hardest case to reach is a transmit write that lands in exactly the cycle where sleep entry would otherwise take effect. To get there, the idle flags are held for precisely one edge, and the write strobe is raised just before the second edge. The bench then confirms that the enable never drops, and that a new sleep window starts only after the write. The receive wake path is checked by counting the synchronizer stages edge by edge after an RX level change while the receiver is asleep.

// File: rtl/uart_pwr_pkg.sv
package uart_pwr_pkg;
  typedef enum logic {PS_AWAKE = 1'b0, PS_ASLEEP = 1'b1} pwr_state_e;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/uart_pwr_sync.sv
module uart_pwr_sync
  import uart_pwr_pkg::*;
#(
  parameter int unsigned W       = 2,
  parameter bit          RST_LVL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] edge_o
);
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= {W{RST_LVL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  // last stage only feeds the edge compare
  assign edge_o = stg_q[SYNC_STAGES-1] ^ stg_q[SYNC_STAGES];
endmodule

// File: rtl/uart_pwr_half.sv
module uart_pwr_half
  import uart_pwr_pkg::*;
#(
  parameter bit COMB_WAKE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_en_i,
  input  logic idle_i,
  input  logic wake_i,
  input  logic force_pd_i,
  output logic en_o
);
  pwr_state_e st_q, st_d;
  logic       idle_q;
  logic       idle_now;

  assign idle_now = auto_en_i & idle_i & ~wake_i;

  always_comb begin
    st_d = st_q;
    if (wake_i || !auto_en_i)   st_d = PS_AWAKE;
    else if (idle_now && idle_q) st_d = PS_ASLEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PS_AWAKE;
      idle_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idle_q <= idle_now;
    end
  end

  generate
    if (COMB_WAKE) begin : g_comb_wake
      assign en_o = ~force_pd_i & ((st_q == PS_AWAKE) | wake_i);
    end else begin : g_reg_wake
      assign en_o = ~force_pd_i & (st_q == PS_AWAKE);
    end
  endgenerate
endmodule

// File: rtl/uart_pwr_ctl.sv
module uart_pwr_ctl #(
  parameter int unsigned N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_good_i,
  input  logic [N_CH-1:0] dir_pd_i,
  input  logic [N_CH-1:0] auto_en_i,
  input  logic [N_CH-1:0] thr_empty_i,
  input  logic [N_CH-1:0] tsr_empty_i,
  input  logic [N_CH-1:0] rx_fifo_empty_i,
  input  logic [N_CH-1:0] rx_idle_i,
  input  logic [N_CH-1:0] thr_wr_i,
  input  logic [N_CH-1:0] rxd_i,
  input  logic [N_CH-1:0] ri_i,
  output logic [N_CH-1:0] tx_en_o,
  output logic [N_CH-1:0] rx_en_o,
  output logic [N_CH-1:0] ri_irq_o
);
  logic [N_CH-1:0] rx_edge;
  logic [N_CH-1:0] force_pd;

  assign force_pd = dir_pd_i | {N_CH{~pwr_good_i}};

  uart_pwr_sync #(.W(N_CH), .RST_LVL(1'b1)) u_rxd_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .edge_o(rx_edge)
  );

  uart_pwr_sync #(.W(N_CH), .RST_LVL(1'b0)) u_ri_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(ri_i), .edge_o(ri_irq_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    uart_pwr_half #(.COMB_WAKE(1'b1)) u_tx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .auto_en_i (auto_en_i[c]),
      .idle_i    (thr_empty_i[c] & tsr_empty_i[c]),
      .wake_i    (thr_wr_i[c]),
      .force_pd_i(force_pd[c]),
      .en_o      (tx_en_o[c])
    );
    uart_pwr_half #(.COMB_WAKE(1'b0)) u_rx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .auto_en_i (auto_en_i[c]),
      .idle_i    (rx_fifo_empty_i[c] & rx_idle_i[c]),
      .wake_i    (rx_edge[c]),
      .force_pd_i(force_pd[c]),
      .en_o      (rx_en_o[c])
    );
  end
endmodule

// File: rtl/uart_pwr_ctl_chk.sv
module uart_pwr_ctl_chk #(
  parameter int unsigned N_CH = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pwr_good_i,
  input logic [N_CH-1:0] dir_pd_i,
  input logic [N_CH-1:0] auto_en_i,
  input logic [N_CH-1:0] thr_wr_i,
  input logic [N_CH-1:0] tx_en_o,
  input logic [N_CH-1:0] rx_en_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    a_r2_direct_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dir_pd_i[c] |-> (!tx_en_o[c] && !rx_en_o[c]));

    a_r3_pwr_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_good_i |-> (!tx_en_o[c] && !rx_en_o[c]));

    a_r4_auto_off_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!auto_en_i[c] && $past(!auto_en_i[c]) && pwr_good_i && !dir_pd_i[c])
        |-> (tx_en_o[c] && rx_en_o[c]));

    a_r7_tx_wake_comb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thr_wr_i[c] && pwr_good_i && !dir_pd_i[c]) |-> tx_en_o[c]);

    a_r10_wake_beats_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thr_wr_i[c] && pwr_good_i && !dir_pd_i[c])
        |=> (tx_en_o[c] || dir_pd_i[c] || !pwr_good_i));
  end
endmodule

bind uart_pwr_ctl uart_pwr_ctl_chk #(.N_CH(N_CH)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_good_i(pwr_good_i),
  .dir_pd_i  (dir_pd_i),
  .auto_en_i (auto_en_i),
  .thr_wr_i  (thr_wr_i),
  .tx_en_o   (tx_en_o),
  .rx_en_o   (rx_en_o)
);

// File: tb/uart_pwr_ctl_tb_top.sv
module uart_pwr_ctl_tb_top;
  localparam int unsigned N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic         pwr_good;
  logic [N-1:0] dir_pd, auto_en, thr_empty, tsr_empty, fifo_empty, rx_idle, thr_wr, rxd, ri;
  logic [N-1:0] tx_en, rx_en, ri_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_pwr_ctl #(.N_CH(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .dir_pd_i(dir_pd),
    .auto_en_i(auto_en), .thr_empty_i(thr_empty), .tsr_empty_i(tsr_empty),
    .rx_fifo_empty_i(fifo_empty), .rx_idle_i(rx_idle), .thr_wr_i(thr_wr),
    .rxd_i(rxd), .ri_i(ri), .tx_en_o(tx_en), .rx_en_o(rx_en), .ri_irq_o(ri_irq)
  );

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // advance n rising edges, land mid low phase
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic idle_all_off();
    auto_en = '0; thr_empty = '0; tsr_empty = '0; fifo_empty = '0; rx_idle = '0;
    step(1);
  endtask

  task automatic t_reset();
    step(1);
    check(tx_en, 2'b11, "R1 tx_en");
    check(rx_en, 2'b11, "R1 rx_en");
    check(ri_irq, 2'b00, "R1 ri_irq");
  endtask

  task automatic t_direct();
    dir_pd = 2'b01; #1;
    check(tx_en, 2'b10, "R2 tx_en forced ch0");
    check(rx_en, 2'b10, "R2 rx_en forced ch0");
    dir_pd = 2'b00; step(1);
    check(tx_en & rx_en, 2'b11, "R2 release");
  endtask

  task automatic t_pwrgood();
    pwr_good = 1'b0; #1;
    check(tx_en | rx_en, 2'b00, "R3 all down");
    pwr_good = 1'b1; step(1);
    check(tx_en & rx_en, 2'b11, "R3 release");
  endtask

  task automatic t_auto_off();
    thr_empty = 2'b11; tsr_empty = 2'b11; fifo_empty = 2'b11; rx_idle = 2'b11;
    step(4);
    check(tx_en, 2'b11, "R4 tx no sleep");
    check(rx_en, 2'b11, "R4 rx no sleep");
    idle_all_off();
  endtask

  task automatic t_tx_sleep();
    auto_en = 2'b01; thr_empty = 2'b01; tsr_empty = 2'b00;
    step(4);
    check(tx_en, 2'b11, "R5 one flag only");
    tsr_empty = 2'b01;
    step(1);
    check(tx_en, 2'b11, "R5 awake after first edge");
    step(1);
    check(tx_en, 2'b10, "R5 asleep after second edge");
    check(rx_en, 2'b11, "R11 rx and other channel awake");
  endtask

  task automatic t_tx_wake();
    thr_wr = 2'b01; #1;
    check(tx_en, 2'b11, "R7 same-cycle wake");
    step(1);
    thr_wr = 2'b00; #1;
    check(tx_en, 2'b11, "R7 awake after write edge");
    step(1);
    check(tx_en, 2'b11, "R5 first idle edge after write");
    step(1);
    check(tx_en, 2'b10, "R5 re-sleep");
    idle_all_off();
  endtask

  task automatic t_priority();
    auto_en = 2'b01; thr_empty = 2'b01; tsr_empty = 2'b01;
    step(1);
    thr_wr = 2'b01;
    step(1);
    thr_wr = 2'b00; #1;
    check(tx_en, 2'b11, "R10 write beats sleep");
    step(1);
    check(tx_en, 2'b11, "R10 new window after write");
    step(1);
    check(tx_en, 2'b10, "R10 sleep after fresh window");
    idle_all_off();
  endtask

  task automatic t_rx();
    auto_en = 2'b10; fifo_empty = 2'b10; rx_idle = 2'b10;
    step(1);
    check(rx_en, 2'b11, "R6 awake after first edge");
    step(1);
    check(rx_en, 2'b01, "R6 asleep after second edge");
    check(tx_en, 2'b11, "R11 tx stays awake");
    rxd = 2'b01;
    step(1);
    check(rx_en, 2'b01, "R8 asleep edge 1");
    step(1);
    check(rx_en, 2'b01, "R8 asleep edge 2");
    step(1);
    check(rx_en, 2'b11, "R8 awake edge 3");
    rxd = 2'b11;
    idle_all_off();
    step(3);
  endtask

  task automatic t_ri();
    dir_pd = 2'b11;
    ri = 2'b01;
    step(1);
    check(ri_irq, 2'b00, "R9 no pulse edge 1");
    step(1);
    check(ri_irq, 2'b01, "R9 pulse edge 2 while down");
    step(1);
    check(ri_irq, 2'b00, "R9 pulse one cycle");
    check(tx_en | rx_en, 2'b00, "R2 still down during ri");
    dir_pd = 2'b00;
    step(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    pwr_good = 1'b1; dir_pd = '0; auto_en = '0; thr_empty = '0; tsr_empty = '0;
    fifo_empty = '0; rx_idle = '0; thr_wr = '0; rxd = '1; ri = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_pwrgood();
    t_auto_off();
    t_tx_sleep();
    t_tx_wake();
    t_priority();
    t_rx();
    t_ri();
    finish_run();
  end
endmodule